// File: doc/BRIEF.md
# Wide Instruction and Lookup Table Programming Port

This block lets a 32-bit register bus load and inspect two stores that an execution engine elsewhere on the chip consumes. The first store holds a few very wide instruction words. The second is a byte-addressed lookup table. The bus has four word registers. A host writes a select register to choose a location, then reads or writes the matching data register to move one 32-bit window.

An instruction does not fill a whole number of bus words. Its final slice therefore carries a single meaningful bit. The lookup table is reached through an element index and a width mode. Together they scale the index to a byte address that wraps at the end of the table. Reads on the bus return data one cycle after the request, flagged by a valid strobe. Writes return nothing.

Top module: `wide_prog_port`

## Requirements
- R1: After reset, both select registers read as zero and every instruction slice reads as zero.
- R2: Register word address 0 is the instruction select. Bits [2:0] pick one of 8 slots and bits [6:3] pick the 32-bit slice position. The register reads back these 7 bits, and its upper bits are ignored on write and read as zero.
- R3: Register word address 1 is the instruction data port. For slice positions 0 to 7, a write replaces instruction bits [32p+31:32p] of the selected slot, and a read returns those bits.
- R4: Each instruction is 257 bits. Slice position 8 maps instruction bit 256 to data bit 0. A write there ignores data bits [31:1], and a read returns those bits as zero.
- R5: Slice positions 9 to 15 are out of range. Writes there change no stored bit, and reads return zero.
- R6: A data write changes only the addressed slice of the addressed slot.
- R7: Register word address 2 is the table select. The element index is in bits [10:0] and the width mode in bits [12:11]. The register reads back these 13 bits, and its upper bits read as zero.
- R8: Width mode 0 accesses one byte at byte address equal to the index. A write changes only that byte (data bits [7:0]), and a read zero-extends it.
- R9: Width mode 1 accesses two bytes at byte address 2×index, little-endian (the lower address holds data bits [7:0]). A write changes only those two bytes, and a read zero-extends them.
- R10: Width mode 2 accesses four bytes at byte address 4×index, little-endian. Register word address 3 is the table data port for every mode.
- R11: Width mode 3 is reserved and addresses the table exactly as mode 2 does.
- R12: The table holds 2048 bytes, and a scaled byte address past the end wraps modulo 2048.
- R13: A read request (req_i high, we_i low) yields rvalid_o high with rdata_o valid in the following cycle. A write request never raises rvalid_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |

## Verification
The bench builds the block with its default parameters: 8 slots of 257 bits and a 2048-byte table. At these values the partial ninth slice and the seven unused slice codes both exist, so the masked and out-of-range cases can be exercised. The 2048-byte table also equals the 11-bit index range. That puts the wrap point within reach of the 2-byte and 4-byte modes, but not of the 1-byte mode.

// File: rtl/wpp_pkg.sv
package wpp_pkg;
  localparam int BUS_DW = 32;

  typedef enum logic [1:0] {
    RA_INST_SEL  = 2'd0,
    RA_INST_DATA = 2'd1,
    RA_LUT_SEL   = 2'd2,
    RA_LUT_DATA  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    LW_BYTE = 2'd0,
    LW_HALF = 2'd1,
    LW_WORD = 2'd2,
    LW_RSVD = 2'd3
  } lut_width_e;

  // log2 of element size in bytes; reserved code aliases to word
  function automatic logic [1:0] elem_shift(lut_width_e m);
    case (m)
      LW_BYTE: return 2'd0;
      LW_HALF: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/wpp_sel_regs.sv
module wpp_sel_regs #(
  parameter int IDX_W  = 3,
  parameter int POS_W  = 4,
  parameter int LUT_AW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_inst_sel_i,
  input  logic              wr_lut_sel_i,
  input  logic [IDX_W+POS_W-1:0] inst_fld_i,
  input  logic [LUT_AW+1:0] lut_fld_i,
  output logic [IDX_W-1:0]  slot_o,
  output logic [POS_W-1:0]  pos_o,
  output logic [LUT_AW-1:0] lut_idx_o,
  output logic [1:0]        lut_mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o <= '0;
      pos_o  <= '0;
    end else if (wr_inst_sel_i) begin
      slot_o <= inst_fld_i[IDX_W-1:0];
      pos_o  <= inst_fld_i[IDX_W+POS_W-1:IDX_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lut_idx_o  <= '0;
      lut_mode_o <= '0;
    end else if (wr_lut_sel_i) begin
      lut_idx_o  <= lut_fld_i[LUT_AW-1:0];
      lut_mode_o <= lut_fld_i[LUT_AW+1:LUT_AW];
    end
  end
endmodule

// File: rtl/wpp_inst_store.sv
module wpp_inst_store #(
  parameter int NUM_INST  = 8,
  parameter int INST_BITS = 257,
  parameter int DW        = 32,
  parameter int IDX_W     = 3,
  parameter int POS_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] slot_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int NSLICE = (INST_BITS + DW - 1) / DW;
  localparam int PAD    = NSLICE * DW;
  localparam int SH_W   = $clog2(PAD);
  // padding bits above INST_BITS are never written and stay zero
  localparam logic [PAD-1:0] VALID = {PAD{1'b1}} >> (PAD - INST_BITS);

  logic [PAD-1:0] mem [NUM_INST];
  logic           in_range;
  logic [SH_W-1:0] shamt;
  logic [PAD-1:0] wmask, wbus;

  always_comb begin
    in_range = int'(pos_i) < NSLICE;
    shamt    = in_range ? SH_W'(int'(pos_i) * DW) : '0;
    wmask    = (PAD'({DW{1'b1}}) << shamt) & VALID;
    wbus     = PAD'(wdata_i) << shamt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_INST; i++) mem[i] <= '0;
    end else if (we_i && in_range) begin
      mem[slot_i] <= (mem[slot_i] & ~wmask) | (wbus & wmask);
    end
  end

  assign rdata_o = in_range ? mem[slot_i][shamt +: DW] : '0;
endmodule

// File: rtl/wpp_lut_store.sv
module wpp_lut_store #(
  parameter int LUT_BYTES = 2048,
  parameter int DW        = 32,
  parameter int LUT_AW    = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [LUT_AW-1:0] base_i,
  input  logic [1:0]        shift_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int LANES = DW / 8;

  logic [7:0] mem [LUT_BYTES];

  // base is element-aligned, so lanes never straddle the wrap point
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int k = 0; k < LANES; k++) begin
        if (k < (1 << shift_i)) mem[base_i + LUT_AW'(k)] <= wdata_i[8*k +: 8];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < (1 << shift_i)) rdata_o[8*k +: 8] = mem[base_i + LUT_AW'(k)];
    end
  end
endmodule

// File: rtl/wide_prog_port.sv
module wide_prog_port #(
  parameter int NUM_INST  = 8,
  parameter int INST_BITS = 257,
  parameter int LUT_BYTES = 2048
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic        rvalid_o,
  output logic [31:0] rdata_o
);
  import wpp_pkg::*;

  localparam int DW     = BUS_DW;
  localparam int IDX_W  = $clog2(NUM_INST);
  localparam int NSLICE = (INST_BITS + DW - 1) / DW;
  localparam int POS_W  = $clog2(NSLICE);
  localparam int LUT_AW = $clog2(LUT_BYTES);
  localparam int SEL_W  = IDX_W + POS_W;

  reg_addr_e         ra;
  logic              wr, rd;
  logic [IDX_W-1:0]  inst_slot;
  logic [POS_W-1:0]  inst_pos;
  logic [LUT_AW-1:0] lut_idx, lut_base;
  logic [1:0]        lut_mode, lut_shift;
  logic [DW-1:0]     inst_rdata, lut_rdata, rd_mux;

  assign ra = reg_addr_e'(addr_i);
  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  wpp_sel_regs #(.IDX_W(IDX_W), .POS_W(POS_W), .LUT_AW(LUT_AW)) u_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_inst_sel_i(wr && ra == RA_INST_SEL),
    .wr_lut_sel_i (wr && ra == RA_LUT_SEL),
    .inst_fld_i   (wdata_i[SEL_W-1:0]),
    .lut_fld_i    (wdata_i[LUT_AW+1:0]),
    .slot_o       (inst_slot),
    .pos_o        (inst_pos),
    .lut_idx_o    (lut_idx),
    .lut_mode_o   (lut_mode)
  );

  wpp_inst_store #(
    .NUM_INST(NUM_INST), .INST_BITS(INST_BITS), .DW(DW),
    .IDX_W(IDX_W), .POS_W(POS_W)
  ) u_inst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr && ra == RA_INST_DATA),
    .slot_i (inst_slot),
    .pos_i  (inst_pos),
    .wdata_i(wdata_i),
    .rdata_o(inst_rdata)
  );

  // index scaled by element size; overflow bits drop, giving the wrap
  assign lut_shift = elem_shift(lut_width_e'(lut_mode));
  assign lut_base  = lut_idx << lut_shift;

  wpp_lut_store #(.LUT_BYTES(LUT_BYTES), .DW(DW), .LUT_AW(LUT_AW)) u_lut (
    .clk_i  (clk_i),
    .we_i   (wr && ra == RA_LUT_DATA),
    .base_i (lut_base),
    .shift_i(lut_shift),
    .wdata_i(wdata_i),
    .rdata_o(lut_rdata)
  );

  always_comb begin
    rd_mux = '0;
    case (ra)
      RA_INST_SEL:  rd_mux[SEL_W-1:0]    = {inst_pos, inst_slot};
      RA_INST_DATA: rd_mux               = inst_rdata;
      RA_LUT_SEL:   rd_mux[LUT_AW+1:0]   = {lut_mode, lut_idx};
      default:      rd_mux               = lut_rdata;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/wpp_chk.sv
module wpp_chk #(
  parameter int DW     = 32,
  parameter int POS_W  = 4,
  parameter int NSLICE = 9,
  parameter int LAST_W = 1,
  parameter int SEL_W  = 7,
  parameter int LSEL_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [POS_W-1:0] inst_pos,
  input logic [1:0]       lut_mode,
  input logic             rvalid_i,
  input logic [DW-1:0]    rdata_i
);
  import wpp_pkg::*;

  a_r13_read_answers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_i);

  a_r13_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_i);

  a_r5_oob_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == RA_INST_DATA && int'(inst_pos) >= NSLICE)
    |=> rdata_i == '0);

  a_r4_last_slice_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == RA_INST_DATA && int'(inst_pos) == NSLICE - 1)
    |=> (rdata_i >> LAST_W) == '0);

  a_r8_byte_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == RA_LUT_DATA && lut_mode == LW_BYTE)
    |=> rdata_i[DW-1:8] == '0);

  a_r9_half_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == RA_LUT_DATA && lut_mode == LW_HALF)
    |=> rdata_i[DW-1:16] == '0);

  a_r2_sel_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == RA_INST_SEL) |=> (rdata_i >> SEL_W) == '0);

  a_r7_sel_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == RA_LUT_SEL) |=> (rdata_i >> LSEL_W) == '0);
endmodule

bind wide_prog_port wpp_chk #(
  .DW(DW), .POS_W(POS_W), .NSLICE(NSLICE),
  .LAST_W(INST_BITS - (NSLICE - 1) * DW),
  .SEL_W(SEL_W), .LSEL_W(LUT_AW + 2)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .inst_pos(inst_pos),
  .lut_mode(lut_mode),
  .rvalid_i(rvalid_o),
  .rdata_i (rdata_o)
);

// File: tb/tb_wide_prog_port.sv
`timescale 1ns/1ps
module tb_wide_prog_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rvalid;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference model
  logic [256:0] m_inst [8];
  logic [7:0]   m_lut  [2048];
  int s_slot = 0, s_pos = 0, s_idx = 0, s_mode = 0;

  always #2.5 clk = ~clk;

  wide_prog_port dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata)
  );

  // monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R13: unexpected rvalid, got %h exp none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: got %h exp %h", t, rdata, e);
        end
      end
    end
  end

  task automatic bus(input logic [1:0] a, input logic w, input logic [31:0] d,
                     input logic [31:0] e, input string t);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    if (!w) begin exp_q.push_back(e); tag_q.push_back(t); end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  function automatic int lut_base(int idx, int mode);
    int sh = (mode == 0) ? 0 : (mode == 1) ? 1 : 2;
    return (idx << sh) % 2048;
  endfunction

  function automatic int lut_n(int mode);
    return (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
  endfunction

  task automatic inst_sel(input int slot, input int pos);
    s_slot = slot; s_pos = pos;
    bus(2'd0, 1'b1, 32'hFFFF_FF80 | 32'(pos << 3) | 32'(slot), '0, "");
  endtask

  task automatic inst_wr(input logic [31:0] d);
    for (int b = 0; b < 32; b++)
      if (s_pos < 9 && s_pos * 32 + b < 257) m_inst[s_slot][s_pos * 32 + b] = d[b];
    bus(2'd1, 1'b1, d, '0, "");
  endtask

  task automatic inst_rd(input string t);
    logic [31:0] e = '0;
    for (int b = 0; b < 32; b++)
      if (s_pos < 9 && s_pos * 32 + b < 257) e[b] = m_inst[s_slot][s_pos * 32 + b];
    bus(2'd1, 1'b0, '0, e, t);
  endtask

  task automatic lut_sel(input int idx, input int mode);
    s_idx = idx; s_mode = mode;
    bus(2'd2, 1'b1, 32'hFFFF_E000 | 32'(mode << 11) | 32'(idx), '0, "");
  endtask

  task automatic lut_wr(input logic [31:0] d);
    int b = lut_base(s_idx, s_mode);
    for (int k = 0; k < lut_n(s_mode); k++) m_lut[(b + k) % 2048] = d[8*k +: 8];
    bus(2'd3, 1'b1, d, '0, "");
  endtask

  task automatic lut_rd(input string t);
    logic [31:0] e = '0;
    int b = lut_base(s_idx, s_mode);
    for (int k = 0; k < lut_n(s_mode); k++) e[8*k +: 8] = m_lut[(b + k) % 2048];
    bus(2'd3, 1'b0, '0, e, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_inst[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus(2'd0, 1'b0, '0, 32'h0, "R1 inst select");
    bus(2'd2, 1'b0, '0, 32'h0, "R1 lut select");
    for (int p = 0; p < 9; p++) begin
      inst_sel(3, p);
      inst_rd("R1 inst slice");
    end

    // R2 select readback, upper bits ignored
    inst_sel(5, 3);
    bus(2'd0, 1'b0, '0, 32'h0000_001D, "R2 select readback");
    inst_sel(7, 15);
    bus(2'd0, 1'b0, '0, 32'h0000_007F, "R2 select max");

    // R3/R4/R6 fill every slice, then read all back
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 9; p++) begin
        inst_sel(s, p);
        inst_wr(32'hA500_0000 ^ 32'(s << 16) ^ 32'(p * 32'h0101) ^ 32'h0000_F00F);
      end
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 9; p++) begin
        inst_sel(s, p);
        inst_rd(p == 8 ? "R4 last slice" : "R3 R6 slice readback");
      end
    inst_sel(4, 8);
    inst_wr(32'hFFFF_FFFE);
    inst_rd("R4 bit256 cleared");
    inst_wr(32'h0000_0003);
    inst_rd("R4 bit256 set");

    // R5 out-of-range slices
    for (int p = 9; p < 16; p++) begin
      inst_sel(2, p);
      inst_wr(32'hDEAD_BEEF);
      inst_rd("R5 oob read zero");
    end
    for (int p = 0; p < 9; p++) begin
      inst_sel(2, p);
      inst_rd("R5 oob write left slot intact");
    end

    // R7 lut select readback
    lut_sel(12'h123, 2);
    bus(2'd2, 1'b0, '0, 32'h0000_1123, "R7 select readback");
    lut_sel(11'h7FF, 3);
    bus(2'd2, 1'b0, '0, 32'h0000_1FFF, "R7 select mode3");

    // R10 fill table by words
    for (int i = 0; i < 512; i++) begin
      lut_sel(i, 2);
      lut_wr(32'h1000_0000 + 32'(i * 32'h0004_0301));
    end
    for (int i = 0; i < 512; i += 37) begin
      lut_sel(i, 2);
      lut_rd("R10 word readback");
    end

    // R8 byte mode
    for (int i = 0; i < 12; i++) begin
      lut_sel(i, 0);
      lut_rd("R8 byte read");
    end
    lut_sel(5, 0);
    lut_wr(32'hCAFE_BE77);
    lut_sel(1, 2);
    lut_rd("R8 byte write only one byte");
    lut_sel(2047, 0);
    lut_rd("R8 top byte");

    // R9 half mode
    for (int i = 0; i < 6; i++) begin
      lut_sel(i, 1);
      lut_rd("R9 half read");
    end
    lut_sel(3, 1);
    lut_wr(32'h5555_A1B2);
    lut_sel(1, 2);
    lut_rd("R9 half write only two bytes");

    // R12 wrap
    lut_sel(600, 2);
    lut_wr(32'h0BAD_F00D);
    lut_sel(88, 2);
    lut_rd("R12 word wrap 600 to 88");
    lut_sel(2047, 1);
    lut_wr(32'h0000_9C3E);
    lut_sel(1023, 1);
    lut_rd("R12 half wrap 2047 to 1023");
    lut_sel(2047, 2);
    lut_rd("R12 word wrap 2047 to 511");

    // R11 reserved mode
    lut_sel(10, 3);
    lut_wr(32'h7654_3210);
    lut_rd("R11 mode3 read");
    lut_sel(10, 2);
    lut_rd("R11 mode3 matches mode2");
    lut_sel(11, 2);
    lut_rd("R11 neighbour intact");

    // R13 final: queue drained, no stray valid
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R13: got %0d pending exp 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule